// File: doc/BRIEF.md
# Oversampled Serial Receiver with Idle Timeout and Flow Control

This block turns an asynchronous serial line into entries for a receive FIFO. Frames are fixed at eight data bits, no parity and one stop bit. The line is sampled on a strobe that runs at fourteen times the bit rate. Each completed frame becomes one 11-bit entry: the received byte, a zero source-empty flag, an error flag and a break flag. The entry is offered on a one-cycle write strobe. A stop bit seen low raises a framing-error event. An all-zero frame whose stop bit is also low is a break, and it raises a break event. After such a frame the receiver ignores the line until it has gone high again.

A second function watches line activity. While the timeout is enabled and the FIFO level reported back to the block is non-zero, it counts sample strobes since the last start bit. It raises a one-cycle timeout event after 4, 8 or 16 character times, where one character time is ten bit periods. A third function drives a request-to-send pin from the FIFO level. When flow control is enabled, the pin drops once the level reaches a selectable threshold. The pin polarity is programmable.

The baud strobe generator and the FIFO storage sit outside this block. The FIFO level is an input.

Top module: `hs_serial_rx`

## Requirements
- R1: A frame is received least significant bit first. The entry carries the byte in bits 7:0 and a 0 in bit 8. It is written with `fifo_wr` high for exactly one cycle: the cycle after the `samp_en` edge that samples the middle of the stop bit. The line passes a two-flop synchronizer before sampling.
- R2: A start bit is confirmed on the seventh strobe after the low level is first seen. If the line is high there, the receiver returns to idle and writes no entry, and the next frame is received normally.
- R3: A stop bit sampled low sets entry bit 9. It also pulses `fe_evt` in the same cycle as the write.
- R4: A frame with all data bits zero and a low stop bit sets both bit 10 and bit 9 of the entry. It pulses `brk_evt` (and `fe_evt`) with the write.
- R5: After a low stop bit, no new start bit is accepted until the line has been sampled high. A line held low for many frame times gives exactly one entry.
- R6: While reset is asserted, `fifo_wr`, `fe_evt`, `brk_evt` and `tmo_evt` are 0 and `rts_o` is 1. Only cycles with `samp_en` high advance the receiver.
- R7: `tmo_sel` 0 disables the timeout. Values 1, 2 and 3 select 4, 8 and 16 character times of 140 strobes each. The counter restarts from zero whenever the level is 0, the timeout is disabled, or a start bit is seen. `tmo_evt` pulses in the cycle after the strobe that completes the count.
- R8: No timeout fires while `fifo_level` is 0. Within one spell of inactivity with data buffered, the timeout fires only once.
- R9: With `rts_en` high, the un-inverted pin is 1 while `fifo_level` is below the threshold and 0 at or above it. The threshold is 8, 16, 32 or 48 for `rts_lvl_sel` 0, 1, 2 or 3. The pin updates one cycle after its inputs change.
- R10: `rts_inv` high inverts the pin. With `rts_en` low, the pin holds the ready level, which is 1 un-inverted and 0 inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| samp_en | input | 1 | Sample strobe at 14x the bit rate |
| tmo_sel | input | 2 | Timeout length: 0 off, 1/2/3 = 4/8/16 characters |
| rts_en | input | 1 | Flow control enable |
| rts_lvl_sel | input | 2 | RTS threshold: 8/16/32/48 entries |
| rts_inv | input | 1 | Invert RTS pin |
| fifo_level | input | 7 | Current receive FIFO occupancy |
| fifo_wr | output | 1 | Entry write strobe |
| fifo_wdata | output | 11 | Entry: {break, error, empty=0, byte} |
| fe_evt | output | 1 | Framing-error event pulse |
| brk_evt | output | 1 | Break event pulse |
| tmo_evt | output | 1 | Receive-timeout event pulse |
| rts_o | output | 1 | Request-to-send pin |

## Verification
A frame's entry and its event pulses appear together, one cycle after the strobe at the middle of the stop bit. The bench holds every bit for a full 14-strobe period and logs each write and event at the falling clock edge. It inspects that log only after the idle gap that follows a frame, so the synchronizer delay cannot move a result past the point where it is read. The timeout is due exactly 140·N strobes after the level turns non-zero, in the cycle after the last of them. The bench counts strobes from the moment it raises the level and compares that count with 560, 1120 or 2240. The RTS pin is due one cycle after an input change, so it is sampled at the next falling edge.

// File: rtl/hs_serial_rx_pkg.sv
package hs_serial_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  // FIFO fill level at which flow control stops the sender
  function automatic logic [5:0] rts_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    rts_limit = 6'd8;
      2'd1:    rts_limit = 6'd16;
      2'd2:    rts_limit = 6'd32;
      default: rts_limit = 6'd48;
    endcase
  endfunction

endpackage

// File: rtl/rxs_framer.sv
module rxs_framer
  import hs_serial_rx_pkg::*;
#(
  parameter int OVS       = 14,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd,
  input  logic                 samp_en,
  output logic                 start_det,
  output logic                 wr_en,
  output logic [DATA_BITS+2:0] wr_data,
  output logic                 fe_pulse,
  output logic                 brk_pulse
);
  localparam int MID     = OVS / 2;
  localparam int CNT_W   = $clog2(OVS);
  localparam int BIT_W   = $clog2(DATA_BITS);
  localparam int ENT_W   = DATA_BITS + 3;
  localparam int POS_ERR = DATA_BITS + 1;
  localparam int POS_BRK = DATA_BITS + 2;

  logic [1:0]           sync_q;
  logic                 rx_s;
  rx_state_e            state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [BIT_W-1:0]     bit_q, bit_d;
  logic [DATA_BITS-1:0] sh_q, sh_d;
  logic [ENT_W-1:0]     data_d;
  logic                 wr_d, fe_d, brk_d, start_d;
  logic                 stop_low, all_zero;

  assign rx_s     = sync_q[1];
  assign stop_low = ~rx_s;
  assign all_zero = (sh_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    data_d  = wr_data;
    wr_d    = 1'b0;
    fe_d    = 1'b0;
    brk_d   = 1'b0;
    start_d = 1'b0;
    if (samp_en) begin
      case (state_q)
        RX_IDLE: begin
          if (!rx_s) begin
            state_d = RX_START;
            cnt_d   = '0;
            start_d = 1'b1;
          end
        end
        RX_START: begin
          if (cnt_q == CNT_W'(MID - 1)) begin
            cnt_d = '0;
            bit_d = '0;
            state_d = rx_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == CNT_W'(OVS - 1)) begin
            cnt_d = '0;
            sh_d  = {rx_s, sh_q[DATA_BITS-1:1]};
            if (bit_q == BIT_W'(DATA_BITS - 1)) state_d = RX_STOP;
            else                                bit_d   = bit_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == CNT_W'(OVS - 1)) begin
            cnt_d   = '0;
            wr_d    = 1'b1;
            fe_d    = stop_low;
            brk_d   = stop_low & all_zero;
            data_d  = {stop_low & all_zero, stop_low, 1'b0, sh_q};
            state_d = rx_s ? RX_IDLE : RX_HOLD;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_HOLD: begin
          if (rx_s) state_d = RX_IDLE;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      cnt_q     <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      wr_data   <= '0;
      wr_en     <= 1'b0;
      fe_pulse  <= 1'b0;
      brk_pulse <= 1'b0;
      start_det <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      bit_q     <= bit_d;
      sh_q      <= sh_d;
      wr_data   <= data_d;
      wr_en     <= wr_d;
      fe_pulse  <= fe_d;
      brk_pulse <= brk_d;
      start_det <= start_d;
    end
  end

  // R1: a frame produces a single-cycle write
  a_r1_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R3: a framing-error event always rides on an entry with the error flag
  a_r3_fe_entry: assert property (@(posedge clk) disable iff (!rst_n)
    fe_pulse |-> (wr_en && wr_data[POS_ERR]));
  // R4: a break entry is all zero data with both flags set
  a_r4_brk_entry: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |-> (wr_en && wr_data[POS_BRK] && wr_data[POS_ERR] &&
                   wr_data[DATA_BITS-1:0] == '0));
  // R5: a start is recognised only out of idle, never while holding after a low stop
  a_r5_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |-> ($past(state_q) == RX_IDLE));

endmodule

// File: rtl/rxs_idle_timer.sv
module rxs_idle_timer #(
  parameter int OVS        = 14,
  parameter int FRAME_BITS = 10,
  parameter int LVL_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_en,
  input  logic             start_det,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [1:0]       tmo_sel,
  output logic             tmo_pulse
);
  localparam int CHAR_ENS = OVS * FRAME_BITS;
  localparam int MAX_ENS  = 16 * CHAR_ENS;
  localparam int TW       = $clog2(MAX_ENS + 1);

  logic [TW-1:0] cnt_q, cnt_d, limit, cnt_inc;
  logic          fired_q, fired_d, pulse_d, clear;

  always_comb begin
    case (tmo_sel)
      2'd1:    limit = TW'(4 * CHAR_ENS);
      2'd2:    limit = TW'(8 * CHAR_ENS);
      2'd3:    limit = TW'(16 * CHAR_ENS);
      default: limit = '0;
    endcase
  end

  assign clear   = start_det || (fifo_level == '0) || (tmo_sel == 2'd0);
  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    cnt_d   = cnt_q;
    fired_d = fired_q;
    pulse_d = 1'b0;
    if (clear) begin
      cnt_d   = '0;
      fired_d = 1'b0;
    end else if (samp_en && !fired_q) begin
      cnt_d = cnt_inc;
      if (cnt_inc >= limit) begin
        pulse_d = 1'b1;
        fired_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      fired_q   <= 1'b0;
      tmo_pulse <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      fired_q   <= fired_d;
      tmo_pulse <= pulse_d;
    end
  end

  // R8: a timeout needs buffered data and an enabled timeout
  a_r8_tmo_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |-> $past(fifo_level != '0 && tmo_sel != 2'd0));
  // R8: one pulse per inactivity spell
  a_r8_tmo_once: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |=> !tmo_pulse);
  // R7: the pulse follows a counting strobe
  a_r7_tmo_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |-> $past(samp_en));

endmodule

// File: rtl/rxs_flow_ctl.sv
module rxs_flow_ctl
  import hs_serial_rx_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             rts_en,
  input  logic [1:0]       rts_lvl_sel,
  input  logic             rts_inv,
  output logic             rts_o
);
  logic [LVL_W-1:0] thr;
  logic             ready, rts_d;

  assign thr   = LVL_W'(rts_limit(rts_lvl_sel));
  assign ready = !rts_en || (fifo_level < thr);
  assign rts_d = ready ^ rts_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_o <= 1'b1;
    else        rts_o <= rts_d;
  end

  // R10: disabled flow control holds the ready level
  a_r10_rts_off: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rts_en) |-> (rts_o == !$past(rts_inv)));
  // R9: at or above the largest threshold the sender is always stopped
  a_r9_rts_full: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rts_en && fifo_level >= LVL_W'(48)) |-> (rts_o == $past(rts_inv)));
  // R9: an empty FIFO always allows sending
  a_r9_rts_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fifo_level == '0) |-> (rts_o == !$past(rts_inv)));

endmodule

// File: rtl/hs_serial_rx.sv
module hs_serial_rx #(
  parameter int OVS       = 14,
  parameter int DATA_BITS = 8,
  parameter int LVL_W     = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd,
  input  logic                 samp_en,
  input  logic [1:0]           tmo_sel,
  input  logic                 rts_en,
  input  logic [1:0]           rts_lvl_sel,
  input  logic                 rts_inv,
  input  logic [LVL_W-1:0]     fifo_level,
  output logic                 fifo_wr,
  output logic [DATA_BITS+2:0] fifo_wdata,
  output logic                 fe_evt,
  output logic                 brk_evt,
  output logic                 tmo_evt,
  output logic                 rts_o
);
  localparam int FRAME_BITS = DATA_BITS + 2;

  logic [1:0] rst_pipe;
  logic       rst_int_n;
  logic       start_det;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  rxs_framer #(.OVS(OVS), .DATA_BITS(DATA_BITS)) u_framer (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rxd       (rxd),
    .samp_en   (samp_en),
    .start_det (start_det),
    .wr_en     (fifo_wr),
    .wr_data   (fifo_wdata),
    .fe_pulse  (fe_evt),
    .brk_pulse (brk_evt)
  );

  rxs_idle_timer #(.OVS(OVS), .FRAME_BITS(FRAME_BITS), .LVL_W(LVL_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .samp_en    (samp_en),
    .start_det  (start_det),
    .fifo_level (fifo_level),
    .tmo_sel    (tmo_sel),
    .tmo_pulse  (tmo_evt)
  );

  rxs_flow_ctl #(.LVL_W(LVL_W)) u_flow (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .fifo_level  (fifo_level),
    .rts_en      (rts_en),
    .rts_lvl_sel (rts_lvl_sel),
    .rts_inv     (rts_inv),
    .rts_o       (rts_o)
  );

  // R6: no event while the block is held in reset
  a_r6_quiet_in_reset: assert property (@(posedge clk)
    !rst_int_n |-> (!fifo_wr && !fe_evt && !brk_evt && !tmo_evt));

endmodule

// File: tb/sim_hs_serial_rx.sv
module sim_hs_serial_rx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rxd;
  logic        samp_en;
  logic [1:0]  tmo_sel;
  logic        rts_en;
  logic [1:0]  rts_lvl_sel;
  logic        rts_inv;
  logic [6:0]  fifo_level;
  logic        fifo_wr;
  logic [10:0] fifo_wdata;
  logic        fe_evt, brk_evt, tmo_evt, rts_o;

  integer total = 0, bad = 0;
  integer en_count = 0, wr_seen = 0, fe_seen = 0, brk_seen = 0, tmo_seen = 0;
  integer tmo_base = 0, tmo_at = 0;
  logic [10:0] wr_log [0:63];

  // {stop bit, byte, expected entry}
  localparam logic [19:0] VEC [0:7] = '{
    {1'b1, 8'h55, 11'h055},
    {1'b1, 8'hA3, 11'h0A3},
    {1'b1, 8'h00, 11'h000},
    {1'b1, 8'hFF, 11'h0FF},
    {1'b0, 8'h3C, 11'h23C},
    {1'b0, 8'h00, 11'h600},
    {1'b1, 8'h81, 11'h081},
    {1'b0, 8'hC4, 11'h2C4}
  };

  always #5 clk = ~clk;

  hs_serial_rx u0 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .samp_en(samp_en),
    .tmo_sel(tmo_sel), .rts_en(rts_en), .rts_lvl_sel(rts_lvl_sel),
    .rts_inv(rts_inv), .fifo_level(fifo_level), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .fe_evt(fe_evt), .brk_evt(brk_evt),
    .tmo_evt(tmo_evt), .rts_o(rts_o)
  );

  // strobe generator and output log, all at the falling edge
  initial begin
    samp_en = 1'b0;
    forever begin
      @(negedge clk);
      if (samp_en) en_count++;
      if (fifo_wr) begin
        if (wr_seen < 64) wr_log[wr_seen] = fifo_wdata;
        wr_seen++;
      end
      if (fe_evt)  fe_seen++;
      if (brk_evt) brk_seen++;
      if (tmo_evt) begin
        tmo_seen++;
        tmo_at = en_count - tmo_base;
      end
      samp_en = ~samp_en;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ens(input integer n);
    integer t;
    t = en_count + n;
    while (en_count < t) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop);
    rxd = 1'b0;
    wait_ens(14);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      wait_ens(14);
    end
    rxd = stop;
    wait_ens(14);
    rxd = 1'b1;
    wait_ens(14);
  endtask

  task automatic rts_case(input logic en, input logic [1:0] sel, input logic inv,
                          input logic [6:0] lvl, input logic exp, input string req);
    rts_en = en; rts_lvl_sel = sel; rts_inv = inv; fifo_level = lvl;
    @(negedge clk);
    chk(req, {31'd0, rts_o}, {31'd0, exp});
  endtask

  task automatic tmo_case(input logic [1:0] sel, input integer exp_ens, input string req);
    integer t0;
    fifo_level = 7'd0;
    tmo_sel = sel;
    wait_ens(4);
    t0 = tmo_seen;
    tmo_base = en_count;
    fifo_level = 7'd1;
    wait_ens(exp_ens + 40);
    chk(req, tmo_seen - t0, 1);
    chk(req, tmo_at, exp_ens);
    wait_ens(exp_ens / 2 + 20);
    chk("R8 single pulse", tmo_seen - t0, 1);
    fifo_level = 7'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    integer w0, f0, b0, t0;
    rst_n = 1'b0; rxd = 1'b1; tmo_sel = 2'd0; rts_en = 1'b0;
    rts_lvl_sel = 2'd0; rts_inv = 1'b0; fifo_level = 7'd0;
    repeat (4) @(negedge clk);
    // R6 reset state
    chk("R6 wr in reset", {31'd0, fifo_wr}, 0);
    chk("R6 tmo in reset", {31'd0, tmo_evt}, 0);
    chk("R6 rts in reset", {31'd0, rts_o}, 1);
    #1 rst_n = 1'b1;
    wait_ens(10);

    // vector table: frames and their entries (R1 R3 R4)
    for (int v = 0; v < 8; v++) begin
      w0 = wr_seen; f0 = fe_seen; b0 = brk_seen;
      send_frame(VEC[v][18:11], VEC[v][19]);
      chk("R1 one entry", wr_seen - w0, 1);
      chk(VEC[v][10] ? "R4 entry" : (VEC[v][9] ? "R3 entry" : "R1 entry"),
          {21'd0, wr_log[w0]}, {21'd0, VEC[v][10:0]});
      chk("R3 fe event", fe_seen - f0, {31'd0, VEC[v][9]});
      chk("R4 brk event", brk_seen - b0, {31'd0, VEC[v][10]});
    end

    // R2 false start
    w0 = wr_seen;
    rxd = 1'b0;
    wait_ens(3);
    rxd = 1'b1;
    wait_ens(30);
    chk("R2 glitch ignored", wr_seen - w0, 0);
    send_frame(8'h5A, 1'b1);
    chk("R2 recovers", wr_seen - w0, 1);
    chk("R2 recovered data", {21'd0, wr_log[w0]}, 32'h05A);

    // R5 long break gives one entry
    w0 = wr_seen; b0 = brk_seen;
    rxd = 1'b0;
    wait_ens(14 * 30);
    rxd = 1'b1;
    wait_ens(30);
    chk("R5 single break entry", wr_seen - w0, 1);
    chk("R5 break data", {21'd0, wr_log[w0]}, 32'h600);
    chk("R5 break event", brk_seen - b0, 1);
    send_frame(8'h96, 1'b1);
    chk("R5 next frame", {21'd0, wr_log[w0 + 1]}, 32'h096);

    // R7 timeout lengths
    tmo_case(2'd1, 560, "R7 4 chars");
    tmo_case(2'd2, 1120, "R7 8 chars");
    tmo_case(2'd3, 2240, "R7 16 chars");

    // R8 no timeout with empty FIFO
    t0 = tmo_seen;
    tmo_sel = 2'd1; fifo_level = 7'd0;
    wait_ens(700);
    chk("R8 empty no tmo", tmo_seen - t0, 0);
    // R7 disabled
    tmo_sel = 2'd0; fifo_level = 7'd5;
    wait_ens(700);
    chk("R7 disabled no tmo", tmo_seen - t0, 0);

    // R7 start bit restarts the count
    fifo_level = 7'd0; tmo_sel = 2'd1;
    wait_ens(4);
    t0 = tmo_seen;
    tmo_base = en_count;
    fifo_level = 7'd1;
    wait_ens(400);
    send_frame(8'h11, 1'b1);
    wait_ens(600);
    chk("R7 restart fires", tmo_seen - t0, 1);
    chk("R7 restart timing", {31'd0, (tmo_at > 955 && tmo_at < 970)}, 1);
    fifo_level = 7'd0; tmo_sel = 2'd0;

    // R9 / R10 flow control
    rts_case(1'b1, 2'd0, 1'b0, 7'd7,  1'b1, "R9 below 8");
    rts_case(1'b1, 2'd0, 1'b0, 7'd8,  1'b0, "R9 at 8");
    rts_case(1'b1, 2'd1, 1'b0, 7'd15, 1'b1, "R9 below 16");
    rts_case(1'b1, 2'd2, 1'b0, 7'd32, 1'b0, "R9 at 32");
    rts_case(1'b1, 2'd3, 1'b0, 7'd47, 1'b1, "R9 below 48");
    rts_case(1'b1, 2'd3, 1'b0, 7'd48, 1'b0, "R9 at 48");
    rts_case(1'b1, 2'd3, 1'b1, 7'd48, 1'b1, "R10 inverted full");
    rts_case(1'b1, 2'd0, 1'b1, 7'd2,  1'b0, "R10 inverted ready");
    rts_case(1'b0, 2'd0, 1'b1, 7'd60, 1'b0, "R10 off inverted");
    rts_case(1'b0, 2'd0, 1'b0, 7'd60, 1'b1, "R10 off plain");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule